// File: doc/BRIEF.md
# Strobe-Timed Peripheral Write Sequencer

This block sits on the host side of a non-multiplexed 8-bit peripheral bus that uses 68xx-style control lines. These are a 3-bit register address, an active-low chip select, a direction line and an active-low data strobe. A local client hands it one write at a time through a request/acknowledge port. Each request carries the register address, the data byte, and a flag that tells whether the target is the address-pointer-low register or the data register. The sequencer then plays out the bus waveform. Every nanosecond minimum of the peripheral is rounded up to whole system clocks from a clock-period parameter.

The peripheral needs a gap between consecutive strobes. That gap is measured in arbitration periods. An arbitration period is one operating-clock period, or two when the slow-arbitration input is high. The operating-clock period is a parameter given in system clocks. The gap also depends on which register the previous write hit and which register the next write hits. The sequencer tracks the time since the last strobe release and holds back the next falling strobe edge until every rule is met.

Top module: `strobe_write_seq`

## Requirements
- R1: While reset is asserted and after its release with no request, chip select and strobe are high, the direction line is high (not writing), the data drive enable is low and the acknowledge is low.
- R2: A request is taken only on a clock edge where the sequencer is idle, `req_valid` is high and `req_ack` is low. On the following cycle address and data are driven, chip select is low, the direction line is low (write) and `bus_data_oe` is high. Requests seen while busy are not taken.
- R3: The strobe falls no earlier than SU clocks after the lines are driven. SU is the largest of the rounded-up address setup (15 ns), select setup (5 ns) and direction setup (10 ns), and at least 1. With the defaults (10 ns clock) SU = 2.
- R4: The strobe stays low for LO clocks. LO is the larger of the rounded-up low width (20 ns) and the rounded-up data setup (30 ns) minus SU, and at least 1. With the defaults LO = 2.
- R5: After the strobe rises, address, data, direction and select stay held for HD clocks. HD is the largest rounded-up hold of address, direction and data (10 ns each), and at least 1. In the same cycle that select and direction are released, `req_ack` is high for exactly one cycle.
- R6: Between a strobe rise and the next strobe fall there are at least max(HI, 4·A − LO) clocks. HI is the rounded-up high width (20 ns, default 2). A is the arbitration period in system clocks.
- R7: When the previous write targeted the address-pointer-low register, the next fall comes at least 4·A clocks after the previous rise.
- R8: When the previous write targeted the data register and the next write targets the address-pointer-low register, the next fall comes at least 5·A clocks after the previous rise.
- R9: A equals `OPR_CLKS` when `slow_arb` is 0 and 2·`OPR_CLKS` when it is 1. With the defaults, A is 2 or 4.
- R10: The first write after reset waits only for its setup time, never for a spacing gap.
- R11: Address and data do not change while chip select is low. The falling strobe edge happens exactly at the later of the setup limit and the spacing limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_arb | input | 1 | 1 doubles the arbitration period |
| req_valid | input | 1 | Write request present; held until acknowledged |
| req_addr | input | 3 | Target register address |
| req_data | input | 8 | Byte to write |
| req_ptr_lo | input | 1 | 1 = address-pointer-low target, 0 = data register target |
| req_ack | output | 1 | One-cycle pulse when the write cycle is finished |
| bus_addr | output | 3 | Bus address lines |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_dir | output | 1 | Direction line, 0 during a write |
| bus_ds_n | output | 1 | Active-low data strobe |
| bus_data | output | 8 | Bus data lines |
| bus_data_oe | output | 1 | High while the sequencer drives the data lines |

## Verification
Two events can land on the same edge. One is the acknowledge of a finished write. The other is the next request, which the client presents while the acknowledge is still high. To provoke this, the bench drives a new request on the same cycle it sees the acknowledge. The sequencer must not take that request until the cycle after the pulse. In a separate case, the end of setup and the expiry of the spacing gap are arranged to compete for the same falling edge. A behavioural model computes when the strobe should fall as the later of the two limits, and the bench compares every output against the model on every cycle.

// File: rtl/strobe_write_seq.sv
module strobe_write_seq #(
  parameter int CLK_NS     = 10,
  parameter int OPR_CLKS   = 2,
  parameter int ADDR_SU_NS = 15,
  parameter int ADDR_HD_NS = 10,
  parameter int CS_SU_NS   = 5,
  parameter int DIR_SU_NS  = 10,
  parameter int DIR_HD_NS  = 10,
  parameter int DAT_SU_NS  = 30,
  parameter int DAT_HD_NS  = 10,
  parameter int LOW_NS     = 20,
  parameter int HIGH_NS    = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_arb,
  input  logic       req_valid,
  input  logic [2:0] req_addr,
  input  logic [7:0] req_data,
  input  logic       req_ptr_lo,
  output logic       req_ack,
  output logic [2:0] bus_addr,
  output logic       bus_cs_n,
  output logic       bus_dir,
  output logic       bus_ds_n,
  output logic [7:0] bus_data,
  output logic       bus_data_oe
);

  function automatic int up(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int SU_C = mx(mx(up(ADDR_SU_NS), up(CS_SU_NS)), mx(up(DIR_SU_NS), 1));
  localparam int LO_C = mx(mx(up(LOW_NS), up(DAT_SU_NS) - SU_C), 1);
  localparam int HD_C = mx(mx(up(ADDR_HD_NS), up(DIR_HD_NS)), mx(up(DAT_HD_NS), 1));
  localparam int HI_C = mx(up(HIGH_NS), 1);
  localparam int CW   = $clog2(10 * OPR_CLKS + SU_C + LO_C + HD_C + HI_C + 4) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_LOW, S_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] ph, since, arb, gap;
  logic          prev_ptr, cur_ptr, have_prev;
  logic          gap_ok, take;

  assign arb    = slow_arb ? CW'(2 * OPR_CLKS) : CW'(OPR_CLKS);
  assign gap_ok = !have_prev || (since >= gap);
  assign take   = (st == S_IDLE) && req_valid && !req_ack;

  always_comb begin
    gap = CW'(HI_C);
    if ((arb << 2) > gap + CW'(LO_C)) gap = (arb << 2) - CW'(LO_C);
    if (prev_ptr && (arb << 2) > gap) gap = arb << 2;
    if (cur_ptr && !prev_ptr && ((arb << 2) + arb) > gap) gap = (arb << 2) + arb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      ph          <= '0;
      since       <= '0;
      prev_ptr    <= 1'b0;
      cur_ptr     <= 1'b0;
      have_prev   <= 1'b0;
      req_ack     <= 1'b0;
      bus_addr    <= '0;
      bus_data    <= '0;
      bus_cs_n    <= 1'b1;
      bus_dir     <= 1'b1;
      bus_ds_n    <= 1'b1;
      bus_data_oe <= 1'b0;
    end else begin
      req_ack <= 1'b0;
      if (since != CMAX) since <= since + 1'b1;
      unique case (st)
        S_IDLE: if (take) begin
          bus_addr    <= req_addr;
          bus_data    <= req_data;
          cur_ptr     <= req_ptr_lo;
          bus_cs_n    <= 1'b0;
          bus_dir     <= 1'b0;
          bus_data_oe <= 1'b1;
          ph          <= CW'(1);
          st          <= S_SETUP;
        end
        S_SETUP: if (ph >= CW'(SU_C) && gap_ok) begin
          bus_ds_n <= 1'b0;
          ph       <= CW'(1);
          st       <= S_LOW;
        end else if (ph != CMAX) begin
          ph <= ph + 1'b1;
        end
        S_LOW: if (ph >= CW'(LO_C)) begin
          bus_ds_n  <= 1'b1;
          since     <= CW'(1);
          prev_ptr  <= cur_ptr;
          have_prev <= 1'b1;
          ph        <= CW'(1);
          st        <= S_HOLD;
        end else begin
          ph <= ph + 1'b1;
        end
        S_HOLD: if (ph >= CW'(HD_C)) begin
          bus_cs_n    <= 1'b1;
          bus_dir     <= 1'b1;
          bus_data_oe <= 1'b0;
          req_ack     <= 1'b1;
          st          <= S_IDLE;
        end else begin
          ph <= ph + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module strobe_write_seq_chk #(
  parameter int CLK_NS     = 10,
  parameter int ADDR_SU_NS = 15,
  parameter int CS_SU_NS   = 5,
  parameter int DIR_SU_NS  = 10,
  parameter int DAT_SU_NS  = 30,
  parameter int LOW_NS     = 20,
  parameter int HIGH_NS    = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ack,
  input logic [2:0] bus_addr,
  input logic       bus_cs_n,
  input logic       bus_dir,
  input logic       bus_ds_n,
  input logic [7:0] bus_data,
  input logic       bus_data_oe
);
  function automatic int up(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  localparam int SU_C = mx(mx(up(ADDR_SU_NS), up(CS_SU_NS)), mx(up(DIR_SU_NS), 1));
  localparam int LO_C = mx(mx(up(LOW_NS), up(DAT_SU_NS) - SU_C), 1);
  localparam int HI_C = mx(up(HIGH_NS), 1);

  logic [15:0] low_run, high_run;
  logic        seen_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run   <= '0;
      high_run  <= '0;
      seen_rise <= 1'b0;
    end else begin
      low_run  <= bus_ds_n ? 16'd0 : low_run + 16'd1;
      high_run <= !bus_ds_n ? 16'd0 : ((high_run == 16'hFFFF) ? high_run : high_run + 16'd1);
      if (!bus_ds_n) seen_rise <= 1'b1;
    end
  end

  p_strobe_in_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ds_n |-> (!bus_cs_n && !bus_dir && bus_data_oe));
  p_lines_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && $past(!bus_cs_n)) |-> ($stable(bus_addr) && $stable(bus_data)));
  p_select_before_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ds_n) |-> $past(!bus_cs_n));
  p_low_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_ds_n) && rst_n) |-> (low_run >= 16'(LO_C)));
  p_high_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_ds_n) && seen_rise) |-> (high_run >= 16'(HI_C)));
  p_release_after_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |-> (bus_ds_n && $past(bus_ds_n)));
  p_ack_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);
  p_ack_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (bus_cs_n && bus_dir && !bus_data_oe));
endmodule

bind strobe_write_seq strobe_write_seq_chk #(
  .CLK_NS(CLK_NS), .ADDR_SU_NS(ADDR_SU_NS), .CS_SU_NS(CS_SU_NS),
  .DIR_SU_NS(DIR_SU_NS), .DAT_SU_NS(DAT_SU_NS), .LOW_NS(LOW_NS), .HIGH_NS(HIGH_NS)
) chk_i (.*);

// File: tb/strobe_write_seq_tb.sv
module strobe_write_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OPR = 2;
  localparam int SU = 2, LO = 2, HD = 1, HI = 2;

  logic clk = 1'b0, rst_n = 1'b0, slow_arb = 1'b0, req_valid = 1'b0, req_ptr_lo = 1'b0;
  logic [2:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic req_ack, bus_cs_n, bus_dir, bus_ds_n, bus_data_oe;
  logic [2:0] bus_addr;
  logic [7:0] bus_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_write_seq #(.CLK_NS(CLK_PERIOD), .OPR_CLKS(OPR)) dut_i (.*);

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  int n, t_acc, t_fall, t_rise, t_rel, last_rise, has_prev, prev_p;
  logic [2:0] e_addr;
  logic [7:0] e_data;
  string ds_tag = "R10";

  function automatic int gap_for(input bit slow, input bit prv, input bit nxt);
    int a, g;
    a = slow ? 2 * OPR : OPR;
    g = HI;
    if (4 * a - LO > g) g = 4 * a - LO;
    if (prv && 4 * a > g) g = 4 * a;
    if (nxt && !prv && 5 * a > g) g = 5 * a;
    return g;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      n = 0; t_acc = -100; t_fall = -100; t_rise = -100; t_rel = -100;
      last_rise = -100000; has_prev = 0; prev_p = 0;
    end else begin
      n = n + 1;
      if (req_valid && n > t_rel + 1) begin
        int f, g;
        t_acc = n; e_addr = req_addr; e_data = req_data;
        f = n + SU; ds_tag = has_prev ? "R3" : "R10";
        if (has_prev) begin
          g = gap_for(slow_arb, prev_p != 0, req_ptr_lo);
          if (last_rise + g > f) begin
            f = last_rise + g;
            if (req_ptr_lo && prev_p == 0) ds_tag = "R8";
            else if (prev_p != 0) ds_tag = "R7";
            else if (slow_arb) ds_tag = "R9";
            else ds_tag = "R6";
          end
        end
        t_fall = f; t_rise = f + LO; t_rel = t_rise + HD;
        last_rise = t_rise; has_prev = 1; prev_p = req_ptr_lo;
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, n, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic xcs, xds;
      cyc++;
      xcs = !(n >= t_acc && n < t_rel);
      xds = !(n >= t_fall && n < t_rise);
      if (!rst_n) begin
        chk("R1 cs_n", bus_cs_n, 1); chk("R1 ds_n", bus_ds_n, 1);
        chk("R1 dir", bus_dir, 1); chk("R1 oe", bus_data_oe, 0); chk("R1 ack", req_ack, 0);
      end else begin
        chk(xcs ? "R5 cs_n" : "R2 cs_n", bus_cs_n, xcs);
        chk("R2 dir", bus_dir, xcs);
        chk("R2 oe", bus_data_oe, !xcs);
        chk((n >= t_fall) ? "R4 ds_n" : ds_tag, bus_ds_n, xds);
        chk("R5 ack", req_ack, n == t_rel);
        if (!xcs) begin
          chk("R11 addr", bus_addr, e_addr);
          chk("R11 data", bus_data, e_data);
        end
      end
      if (cyc > 20000) begin
        total++; bad++; done = 1;
        $display("FAIL watchdog expired at cycle %0d: actual hung expected finish", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input bit p);
    req_valid = 1'b1; req_addr = a; req_data = d; req_ptr_lo = p;
    do @(negedge clk); while (!req_ack);
  endtask

  task automatic rest(input int k);
    req_valid = 1'b0;
    repeat (k) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rest(3);
    wr(3'd1, 8'hA5, 1'b0);
    wr(3'd2, 8'h3C, 1'b0);
    wr(3'd3, 8'h01, 1'b1);
    wr(3'd4, 8'hF0, 1'b0);
    wr(3'd3, 8'h7E, 1'b1);
    wr(3'd3, 8'h81, 1'b1);
    rest(2);
    slow_arb = 1'b1;
    rest(1);
    wr(3'd5, 8'h55, 1'b0);
    wr(3'd6, 8'hAA, 1'b0);
    wr(3'd3, 8'h12, 1'b1);
    wr(3'd7, 8'h34, 1'b0);
    rest(2);
    slow_arb = 1'b0;
    rest(30);
    wr(3'd0, 8'hC3, 1'b0);
    rest(3);
    wr(3'd1, 8'h99, 1'b0);
    rest(4);
    wr(3'd2, 8'h66, 1'b1);
    rest(12);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule